// File: doc/BRIEF.md
# Port-Triggered System Reset Sequencer

This block holds an 8-bit reset control register decoded at I/O port 0CF9h and the small state machine behind it. Software starts a reset by raising the trigger bit in that register. A mode bit picks between a brief active-low processor INIT pulse and a longer hard reset. The hard reset holds the platform reset and suspend-status outputs low.

A second mode bit decides whether a hard reset also performs a full power cycle. In that case the three active-low sleep-state outputs (S3, S4, S5) are first held low for a multi-second window. The hard-reset hold then follows, and at the end of a hard reset the register returns to zero. Three hardware events start the same hard sequence, with the same choice of power cycle: a falling power-good, a second watchdog timeout, and a press of the reset button. All durations are parameters counted in clock cycles.

Top module: `rst_ctl_seq`

## Requirements
- R1: After reset the register reads 00h, busy is 0, and init_n, plt_rst_n, sus_stat_n and the three sleep outputs are all high.
- R2: A write with io_wr high and io_addr equal to 0CF9h stores io_wdata bits 3 (full), 2 (trigger) and 1 (hard select). A read with io_rd high at that address returns {busy, 3'b000, full, trigger, hard, 1'b0}, so bits 6:4 and 0 read as 0. Writes to other addresses change nothing, and io_rdata is 00h when no read of 0CF9h is in progress.
- R3: A sequence starts only on a write that takes the trigger bit from 0 to 1. A write of 1 while the trigger bit is already 1 starts nothing.
- R4: With hard select 0, a trigger drives init_n low for exactly INIT_CYC cycles, starting the cycle after the write. Platform reset and the sleep outputs stay high, and the register keeps its contents.
- R5: With hard select 1 and full 0, plt_rst_n and sus_stat_n are low for exactly HARD_CYC cycles and the sleep outputs stay high. After this the register reads 00h.
- R6: With hard select 1 and full 1, all three sleep outputs go low together for PWR_CYC cycles while plt_rst_n and sus_stat_n are also low. Another HARD_CYC cycles of platform reset follow with the sleep outputs high. After this the register reads 00h.
- R7: When a single write sets the trigger together with the mode bits, the newly written mode bits choose the reset type.
- R8: While a sequence runs, busy reads 1 and new trigger edges start nothing.
- R9: A falling edge on pwr_ok starts a hard sequence, with the power cycle included when the stored full bit is 1.
- R10: The second watchdog timeout pulse starts a hard sequence. A single pulse does not.
- R11: A falling edge on rst_btn_n starts a hard sequence that follows the stored full bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block |
| pwr_ok | input | 1 | Power-good; a falling edge starts a hard sequence |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| rst_btn_n | input | 1 | Reset button, active low |
| init_n | output | 1 | Processor INIT, active low |
| plt_rst_n | output | 1 | Platform reset, active low |
| sus_stat_n | output | 1 | Suspend status, active low |
| slp_s3_n | output | 1 | S3 sleep output, active low |
| slp_s4_n | output | 1 | S4 sleep output, active low |
| slp_s5_n | output | 1 | S5 sleep output, active low |

## Verification
The assertions check on every cycle that INIT and platform reset are never low together, and that the three sleep outputs always move as one. They also check that sleep outputs are only low inside a platform reset, that a soft trigger lowers INIT on the next cycle, and that the register is clear when platform reset releases. The exact pulse lengths are only shown by the bench's scenarios. The same holds for the ignored repeat trigger and ignored edges while busy, the mode chosen by a combined write, and the watchdog count of two.

// File: rtl/rst_ctl_seq.sv
module rst_ctl_seq #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0CF9,
  parameter int INIT_CYC  = 16,
  parameter int HARD_CYC  = 250_000,
  parameter int PWR_CYC   = 1_000_000_000,
  parameter int WDT_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic              wdt_tmo,
  input  logic              rst_btn_n,
  output logic              init_n,
  output logic              plt_rst_n,
  output logic              sus_stat_n,
  output logic              slp_s3_n,
  output logic              slp_s4_n,
  output logic              slp_s5_n
);
  localparam int MAXC = (PWR_CYC > HARD_CYC) ? ((PWR_CYC > INIT_CYC) ? PWR_CYC : INIT_CYC)
                                             : ((HARD_CYC > INIT_CYC) ? HARD_CYC : INIT_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int WW = $clog2(WDT_LIMIT + 1);

  typedef enum logic [1:0] {IDLE, SOFT, PCYC, HARD} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [WW-1:0] wdt_cnt;
  logic full_q, trig_q, hsel_q, pwr_q, btn_q;

  wire hit      = (io_addr == REG_ADDR);
  wire wr_hit   = io_wr & hit;
  wire idle     = (st == IDLE);
  wire sw_go    = idle & wr_hit & io_wdata[2] & ~trig_q;
  wire wdt_fire = wdt_tmo & (wdt_cnt == WW'(WDT_LIMIT - 1));
  wire ext_go   = idle & ((pwr_q & ~pwr_ok) | (btn_q & ~rst_btn_n) | wdt_fire);
  wire eff_full = wr_hit ? io_wdata[3] : full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      wdt_cnt <= '0;
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      hsel_q  <= 1'b0;
      pwr_q   <= 1'b0;
      btn_q   <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;
      btn_q <= rst_btn_n;
      if (wr_hit) {full_q, trig_q, hsel_q} <= io_wdata[3:1];
      if (idle && wdt_tmo) wdt_cnt <= wdt_fire ? '0 : wdt_cnt + 1'b1;
      case (st)
        IDLE: begin
          if (sw_go && !io_wdata[1]) begin
            st  <= SOFT;
            cnt <= CW'(INIT_CYC - 1);
          end else if (sw_go || ext_go) begin
            st  <= eff_full ? PCYC : HARD;
            cnt <= eff_full ? CW'(PWR_CYC - 1) : CW'(HARD_CYC - 1);
          end
        end
        SOFT: begin
          if (cnt == '0) st <= IDLE;
          else cnt <= cnt - 1'b1;
        end
        PCYC: begin
          if (cnt == '0) begin
            st  <= HARD;
            cnt <= CW'(HARD_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        HARD: begin
          if (cnt == '0) begin
            st      <= IDLE;
            full_q  <= 1'b0;
            trig_q  <= 1'b0;
            hsel_q  <= 1'b0;
            wdt_cnt <= '0;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign init_n     = (st != SOFT);
  assign plt_rst_n  = ~((st == HARD) | (st == PCYC));
  assign sus_stat_n = plt_rst_n;
  assign slp_s3_n   = (st != PCYC);
  assign slp_s4_n   = slp_s3_n;
  assign slp_s5_n   = slp_s3_n;
  assign io_rdata   = (io_rd && hit) ? {~idle, 3'b000, full_q, trig_q, hsel_q, 1'b0} : 8'h00;

  // R4
  init_plt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!init_n && !plt_rst_n));

  // R6
  slp_in_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_s3_n |-> (!plt_rst_n && !sus_stat_n));

  // R6
  slp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_s3_n == slp_s4_n) && (slp_s4_n == slp_s5_n));

  // R3
  soft_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && io_wr && hit && io_wdata[2] && !io_wdata[1] && !trig_q) |=> !init_n);

  // R5
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plt_rst_n) |-> (!full_q && !trig_q && !hsel_q));
endmodule

// File: tb/tb_rst_ctl_seq.sv
module tb_rst_ctl_seq;
  localparam int INIT_C = 16, HARD_C = 20, PWR_C = 50;
  logic clk = 0, rst_n = 0, pwr_ok = 1, io_wr = 0, io_rd = 0, wdt_tmo = 0, rst_btn_n = 1;
  logic [15:0] io_addr = 16'h0CF9;
  logic [7:0] io_wdata = 0, io_rdata;
  logic init_n, plt_rst_n, sus_stat_n, slp_s3_n, slp_s4_n, slp_s5_n;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_ctl_seq #(.INIT_CYC(INIT_C), .HARD_CYC(HARD_C), .PWR_CYC(PWR_C)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .wdt_tmo(wdt_tmo),
    .rst_btn_n(rst_btn_n), .init_n(init_n), .plt_rst_n(plt_rst_n), .sus_stat_n(sus_stat_n),
    .slp_s3_n(slp_s3_n), .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n));

  // wdata, init cycles, plt cycles, slp cycles, readback
  localparam int VEC[7][5] = '{
    '{8'h04, 16, 0,  0,  8'h04},
    '{8'h06, 0,  20, 0,  8'h00},
    '{8'h0E, 0,  70, 50, 8'h00},
    '{8'h0C, 16, 0,  0,  8'h0C},
    '{8'hF5, 16, 0,  0,  8'h04},
    '{8'h0A, 0,  0,  0,  8'h0A},
    '{8'h02, 0,  0,  0,  8'h02}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0; io_addr = 16'h0CF9;
  endtask

  task automatic rd(output int v);
    io_rd = 1; #1; v = io_rdata; io_rd = 0;
  endtask

  task automatic count_low(input int n, output int ci, output int cp, output int cs, output int cu);
    ci = 0; cp = 0; cs = 0; cu = 0;
    for (int i = 0; i < n; i++) begin
      if (!init_n) ci++;
      if (!plt_rst_n) cp++;
      if (!slp_s3_n) cs++;
      if (!sus_stat_n) cu++;
      @(negedge clk);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    int ci, cp, cs, cu, v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(v); chk("R1 reg", v, 0);
    chk("R1 outs", {init_n, plt_rst_n, sus_stat_n, slp_s3_n, slp_s4_n, slp_s5_n}, 6'h3F);

    // vector table: R2 R4 R5 R6 R7
    for (int k = 0; k < 7; k++) begin
      wr(16'h0CF9, 8'h00);
      wr(16'h0CF9, 8'(VEC[k][0]));
      count_low(120, ci, cp, cs, cu);
      chk("R4 init", ci, VEC[k][1]);
      chk("R5 plt", cp, VEC[k][2]);
      chk("R6 slp", cs, VEC[k][3]);
      chk("R5 sus", cu, VEC[k][2]);
      rd(v); chk("R2 readback", v, VEC[k][4]);
    end

    // R3 repeat write of 1 ignored
    wr(16'h0CF9, 8'h00);
    wr(16'h0CF9, 8'h04);
    count_low(40, ci, cp, cs, cu); chk("R3 first", ci, 16);
    wr(16'h0CF9, 8'h04);
    count_low(40, ci, cp, cs, cu); chk("R3 repeat", ci, 0);

    // R2 other address ignored
    wr(16'h0CF9, 8'h00);
    wr(16'h0CF8, 8'h04);
    count_low(40, ci, cp, cs, cu); chk("R2 other addr", ci, 0);
    rd(v); chk("R2 other addr reg", v, 0);

    // R8 busy and ignored edge
    wr(16'h0CF9, 8'h06);
    count_low(3, ci, cp, cs, cu);
    rd(v); chk("R8 busy", v, 8'h86);
    wr(16'h0CF9, 8'h00);
    wr(16'h0CF9, 8'h04);
    count_low(40, ci, cp, cs, cu); chk("R8 ignored", ci, 0);
    rd(v); chk("R8 cleared", v, 0);

    // R9 power-good fall, full=1 then full=0
    wr(16'h0CF9, 8'h08);
    pwr_ok = 0; @(negedge clk);
    count_low(120, ci, cp, cs, cu);
    chk("R9 full slp", cs, 50); chk("R9 full plt", cp, 70);
    pwr_ok = 1; @(negedge clk);
    rd(v); chk("R9 reg", v, 0);
    pwr_ok = 0; @(negedge clk);
    count_low(60, ci, cp, cs, cu);
    chk("R9 plain slp", cs, 0); chk("R9 plain plt", cp, 20);
    pwr_ok = 1; @(negedge clk);

    // R10 watchdog
    wdt_tmo = 1; @(negedge clk); wdt_tmo = 0;
    count_low(40, ci, cp, cs, cu); chk("R10 single", cp, 0);
    wdt_tmo = 1; @(negedge clk); wdt_tmo = 0;
    count_low(40, ci, cp, cs, cu); chk("R10 second", cp, 20);

    // R11 reset button
    rst_btn_n = 0; @(negedge clk);
    count_low(40, ci, cp, cs, cu); chk("R11 button", cp, 20);
    rst_btn_n = 1;
    count_low(10, ci, cp, cs, cu);
    rd(v); chk("R11 reg", v, 0);

    finish_up();
  end
endmodule